// File: doc/BRIEF.md
# Vectored Level-Interrupt Controller

This block gathers 64 level-sensitive interrupt inputs and picks one of them for the processor. Every input has a word-wide configuration register of its own. The low seven bits of that register hold an enable marker and a priority. Each clock, the block chooses the eligible input with the highest priority. It publishes the choice through a read-only select register and through a single request line to the processor.

Software programs the controller over a simple synchronous register bus: a byte address, a write strobe, write data and registered read data. Two controller variants are covered by one parameter, `VARIANT`. That parameter selects the enable code, the bit inside the field that marks a source as enabled, and the location of the select register. Inputs are not latched. A request lasts exactly as long as its source line stays high.

Top module: `vlic_ctrl`

## Requirements
- R1: After reset every configuration field reads 0, the select register reads 0 and `irq_o` is low.
- R2: The configuration register for source n sits at byte address 4*n. Bits 6:0 store the written value. Bits 31:7 always read 0, whatever was written.
- R3: A source is eligible when its input is high and its field has the enable bit set. The enable bit is bit 4 for VARIANT 0, whose enable code is 0x51, and bit 5 for VARIANT 1, whose enable code is 0x20. A field of 0, or any field with the enable bit clear, keeps the source out of arbitration.
- R4: Bits 3:0 of a field give the source's priority. Among eligible sources the largest value wins.
- R5: When eligible sources share the highest priority, the lowest source number wins.
- R6: The select register sits at byte 0x10c for VARIANT 0 and at 0x104 for VARIANT 1. Bit 6 is the pending flag, bits 5:0 hold the winning source number, and every other bit reads 0. With no eligible source the whole register reads 0.
- R7: `irq_o` equals the pending flag. It stays high while any eligible source is high and drops when none remains, because nothing is latched.
- R8: The select register and `irq_o` update on the first clock edge after a source input changes. A configuration write takes effect in the eligibility check on the clock after the write edge.
- R9: Writes to the select register or to unmapped addresses change nothing. Reads from unmapped addresses return 0.
- R10: `bus_rdata_o` is registered. It shows the register that was addressed at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | 64 | Level interrupt inputs, one per source |
| bus_addr_i | input | 12 | Byte address of the register access |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The hardest situation to reach is a configuration write that lands while a source is already active. One clock after the write edge the select register must still show the old winner; only one clock later does it change. The bench holds a single source high, writes 0 into that source's field, and samples `irq_o` at both negative edges that follow. Priority ties and disabled-but-active sources are reached from a fixed programming of a few fields, which a vector table then drives with many input patterns.

// File: rtl/vlic_pkg.sv
// Package: constants and helper functions shared by the interrupt controller.
// Assumes VARIANT is 0 or 1; any other value falls back to variant 1 settings.
package vlic_pkg;

    localparam int FIELD_W = 7;
    localparam int PRIO_W  = 4;

    typedef logic [FIELD_W-1:0] cfg_field_t;
    typedef logic [PRIO_W-1:0]  prio_t;

    // Enable code software writes for the chosen variant.
    function automatic cfg_field_t enable_code(input int variant);
        return (variant == 0) ? 7'h51 : 7'h20;
    endfunction

    // Field bit that marks a source as enabled.
    function automatic int enable_bit(input int variant);
        return (variant == 0) ? 4 : 5;
    endfunction

    // Byte offset of the select register.
    function automatic int select_offset(input int variant);
        return (variant == 0) ? 'h10c : 'h104;
    endfunction

endpackage

// File: rtl/vlic_cfg_regs.sv
// Module: per-source configuration fields.
// Holds one 7-bit field per source and writes it when the bus strobe hits that
// source's word. Assumes the word index is already decoded from the byte address.
module vlic_cfg_regs
    import vlic_pkg::*;
#(
    parameter int N_SRC  = 64,
    parameter int WORD_W = 10
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [WORD_W-1:0]        wr_word,
    input  cfg_field_t               wr_data,
    output logic [N_SRC*FIELD_W-1:0] cfg_flat
);

    for (genvar n = 0; n < N_SRC; n++) begin : g_field
        cfg_field_t field_q;

        // Store the field on a write to this source's word; clear on reset.
        always_ff @(posedge clk) begin
            if (!rst_n)
                field_q <= '0;
            else if (wr_en && (wr_word == WORD_W'(n)))
                field_q <= wr_data;
        end

        assign cfg_flat[n*FIELD_W +: FIELD_W] = field_q;

        assert_field_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && (wr_word == WORD_W'(n))) |=> (cfg_flat[n*FIELD_W +: FIELD_W] == $past(wr_data)));
    end

endmodule

// File: rtl/vlic_arbiter.sv
// Module: priority arbiter over all sources.
// Forms the eligibility vector and reduces it in a balanced tree of pairwise
// compares. The lower-numbered side wins ties. Assumes N_SRC is a power of two.
module vlic_arbiter
    import vlic_pkg::*;
#(
    parameter int N_SRC   = 64,
    parameter int VARIANT = 0,
    parameter int ID_W    = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_SRC-1:0]         src,
    input  logic [N_SRC*FIELD_W-1:0] cfg_flat,
    output logic                     win_valid,
    output logic [ID_W-1:0]          win_id
);

    localparam int EN_BIT = enable_bit(VARIANT);
    localparam int LEVELS = $clog2(N_SRC);

    logic [N_SRC-1:0] elig;
    prio_t            prio [N_SRC];

    for (genvar n = 0; n < N_SRC; n++) begin : g_leaf
        assign elig[n] = src[n] & cfg_flat[n*FIELD_W + EN_BIT];
        assign prio[n] = cfg_flat[n*FIELD_W +: PRIO_W];
    end

    logic              lv_v [LEVELS+1][N_SRC];
    prio_t             lv_p [LEVELS+1][N_SRC];
    logic [ID_W-1:0]   lv_i [LEVELS+1][N_SRC];

    // Reduce the candidates level by level; the left (lower) node keeps ties.
    always_comb begin
        for (int lv = 0; lv <= LEVELS; lv++) begin
            for (int k = 0; k < N_SRC; k++) begin
                lv_v[lv][k] = 1'b0;
                lv_p[lv][k] = '0;
                lv_i[lv][k] = '0;
            end
        end
        for (int k = 0; k < N_SRC; k++) begin
            lv_v[0][k] = elig[k];
            lv_p[0][k] = prio[k];
            lv_i[0][k] = ID_W'(k);
        end
        for (int lv = 1; lv <= LEVELS; lv++) begin
            for (int k = 0; k < N_SRC; k++) begin
                if (k < (N_SRC >> lv)) begin
                    if (lv_v[lv-1][2*k] &&
                        (!lv_v[lv-1][2*k+1] || (lv_p[lv-1][2*k] >= lv_p[lv-1][2*k+1]))) begin
                        lv_v[lv][k] = 1'b1;
                        lv_p[lv][k] = lv_p[lv-1][2*k];
                        lv_i[lv][k] = lv_i[lv-1][2*k];
                    end else begin
                        lv_v[lv][k] = lv_v[lv-1][2*k+1];
                        lv_p[lv][k] = lv_p[lv-1][2*k+1];
                        lv_i[lv][k] = lv_i[lv-1][2*k+1];
                    end
                end
            end
        end
    end

    assign win_valid = lv_v[LEVELS][0];
    assign win_id    = lv_i[LEVELS][0];

    logic unused_cfg_bits;
    assign unused_cfg_bits = ^cfg_flat;

    // Check flags: any eligible source that beats the winner, or ties it with a lower number.
    logic beaten;
    logic tie_lost;
    always_comb begin
        beaten   = 1'b0;
        tie_lost = 1'b0;
        for (int k = 0; k < N_SRC; k++) begin
            if (win_valid && elig[k] && (prio[k] > prio[win_id]))
                beaten = 1'b1;
            if (win_valid && elig[k] && (prio[k] == prio[win_id]) && (ID_W'(k) < win_id))
                tie_lost = 1'b1;
        end
    end

    assert_winner_eligible_R3: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> (src[win_id] && cfg_flat[win_id*FIELD_W + EN_BIT]));
    assert_idle_when_none_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!win_valid) |-> ((src & elig) == '0));
    assert_highest_prio_R4: assert property (@(posedge clk) disable iff (!rst_n) !beaten);
    assert_low_index_tie_R5: assert property (@(posedge clk) disable iff (!rst_n) !tie_lost);

endmodule

// File: rtl/vlic_ctrl.sv
// Module: top of the vectored level-interrupt controller.
// Decodes the register bus, registers the arbiter result into the select
// register and the request line, and returns registered read data.
// Assumes word-aligned accesses; address bits 1:0 are ignored.
module vlic_ctrl
    import vlic_pkg::*;
#(
    parameter int N_SRC   = 64,
    parameter int VARIANT = 0,
    parameter int ADDR_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  src_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_we_i,
    input  logic [31:0]       bus_wdata_i,
    output logic [31:0]       bus_rdata_o,
    output logic              irq_o
);

    localparam int WORD_W   = ADDR_W - 2;
    localparam int ID_W     = $clog2(N_SRC);
    localparam int SEL_WORD = select_offset(VARIANT) / 4;

    logic [WORD_W-1:0]        word;
    logic                     cfg_we;
    logic [N_SRC*FIELD_W-1:0] cfg_flat;
    logic                     win_valid;
    logic [ID_W-1:0]          win_id;
    logic                     sel_pend_q;
    logic [ID_W-1:0]          sel_id_q;
    logic [31:0]              rd_next;
    logic [31:0]              rdata_q;

    assign word   = bus_addr_i[ADDR_W-1:2];
    assign cfg_we = bus_we_i && (32'(word) < N_SRC);

    vlic_cfg_regs #(.N_SRC(N_SRC), .WORD_W(WORD_W)) cfg_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_we),
        .wr_word  (word),
        .wr_data  (bus_wdata_i[FIELD_W-1:0]),
        .cfg_flat (cfg_flat)
    );

    vlic_arbiter #(.N_SRC(N_SRC), .VARIANT(VARIANT), .ID_W(ID_W)) arb_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .src       (src_i),
        .cfg_flat  (cfg_flat),
        .win_valid (win_valid),
        .win_id    (win_id)
    );

    // Capture the arbiter result as the select register every clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_pend_q <= 1'b0;
            sel_id_q   <= '0;
        end else begin
            sel_pend_q <= win_valid;
            sel_id_q   <= win_valid ? win_id : '0;
        end
    end

    // Choose read data for the addressed word; unmapped words give zero.
    always_comb begin
        rd_next = '0;
        if (32'(word) < N_SRC)
            rd_next[FIELD_W-1:0] = cfg_flat[word*FIELD_W +: FIELD_W];
        else if (32'(word) == SEL_WORD)
            rd_next[6:0] = {sel_pend_q, 6'(sel_id_q)};
    end

    // Register the read data for the bus.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_q <= '0;
        else
            rdata_q <= rd_next;
    end

    assign bus_rdata_o = rdata_q;
    assign irq_o       = sel_pend_q;

    logic unused_bus_bits;
    assign unused_bus_bits = ^{bus_wdata_i[31:FIELD_W], bus_addr_i[1:0]};

    assert_irq_follows_winner_R7: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |=> irq_o);
    assert_irq_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!win_valid) |=> !irq_o);
    assert_rdata_high_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata_o[31:7] == '0);

endmodule

// File: tb/vlic_ctrl_tb.sv
`timescale 1ns/1ps
// Bench for vlic_ctrl, VARIANT 0: enable bit 4, select register at 0x10c.
module vlic_ctrl_tb_top;

    localparam int NV = 10;
    localparam logic [11:0] SEL_A = 12'h10c;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] src_i = '0;
    logic [11:0] bus_addr_i = '0;
    logic        bus_we_i = 1'b0;
    logic [31:0] bus_wdata_i = '0;
    logic [31:0] bus_rdata_o;
    logic        irq_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    vlic_ctrl #(.N_SRC(64), .VARIANT(0), .ADDR_W(12)) dut_i (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_addr_i(bus_addr_i),
        .bus_we_i(bus_we_i), .bus_wdata_i(bus_wdata_i),
        .bus_rdata_o(bus_rdata_o), .irq_o(irq_o)
    );

    // Input patterns and expected select value {pending, id}.
    localparam logic [63:0] V_SRC [NV] = '{
        64'h0,
        64'h8,
        (64'h1 << 3) | (64'h1 << 10),
        (64'h1 << 10) | (64'h1 << 20),
        (64'h1 << 20) | (64'h1 << 40) | (64'h1 << 63),
        (64'h1 << 63),
        (64'h1 << 5),
        (64'h1 << 5) | (64'h1 << 7),
        {64{1'b1}},
        64'h1
    };
    localparam logic [6:0] V_SEL [NV] = '{
        7'h00, 7'h43, 7'h4A, 7'h4A, 7'h68, 7'h7F, 7'h00, 7'h47, 7'h68, 7'h00
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr_i = a; bus_wdata_i = d; bus_we_i = 1'b1;
        @(negedge clk);
        bus_we_i = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr_i = a; bus_we_i = 1'b0;
        @(negedge clk);
        d = bus_rdata_o;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check("R1 irq after reset", {31'b0, irq_o}, 32'h0);
        bus_read(12'h000, rd); check("R1 cfg0 after reset", rd, 32'h0);
        bus_read(SEL_A, rd);   check("R1 select after reset", rd, 32'h0);

        // R2: field storage and upper bits; R10 read is registered
        bus_write(12'h030, 32'hFFFF_FFFF);
        bus_read(12'h030, rd); check("R2 cfg12 readback", rd, 32'h7F);
        bus_write(12'h030, 32'h0);
        bus_read(12'h030, rd); check("R3 cfg12 cleared", rd, 32'h0);

        // R9: unmapped read
        bus_write(12'h200, 32'hFFFF_FFFF);
        bus_read(12'h200, rd); check("R9 unmapped read", rd, 32'h0);

        // Programming for the vector table (enable bit 4, priority in bits 3:0)
        bus_write(12'h00C, 32'h12);  // src3  prio 2
        bus_write(12'h028, 32'h15);  // src10 prio 5
        bus_write(12'h050, 32'h15);  // src20 prio 5
        bus_write(12'h0A0, 32'h19);  // src40 prio 9
        bus_write(12'h0FC, 32'h19);  // src63 prio 9
        bus_write(12'h014, 32'h0F);  // src5  enable bit clear
        bus_write(12'h01C, 32'h10);  // src7  prio 0
        bus_read(12'h0FC, rd); check("R2 cfg63 at 0xfc", rd, 32'h19);

        // Vector table walk: R3 R4 R5 R6 R7
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            src_i = V_SRC[v];
            @(negedge clk);
            bus_read(SEL_A, rd);
            check($sformatf("R4 R5 R6 select vector %0d", v), rd, {25'b0, V_SEL[v]});
            check($sformatf("R7 irq vector %0d", v), {31'b0, irq_o}, {31'b0, V_SEL[v][6]});
        end

        // R8: one-clock latency on input change; R7: no latching
        @(negedge clk); src_i = '0;
        @(negedge clk);
        src_i = 64'h8;
        #1 check("R8 irq before edge", {31'b0, irq_o}, 32'h0);
        @(negedge clk); check("R8 irq one edge later", {31'b0, irq_o}, 32'h1);
        src_i = '0;
        @(negedge clk); check("R7 irq drops with source", {31'b0, irq_o}, 32'h0);

        // R9: write to select ignored
        src_i = 64'h8;
        @(negedge clk);
        bus_write(SEL_A, 32'h0);
        bus_read(SEL_A, rd); check("R9 select write ignored", rd, 32'h43);

        // R8 + R3: disable by writing 0 while active
        src_i = (64'h1 << 40);
        repeat (2) @(negedge clk);
        check("R8 irq before disable", {31'b0, irq_o}, 32'h1);
        bus_write(12'h0A0, 32'h0);
        check("R8 irq one edge after write", {31'b0, irq_o}, 32'h1);
        @(negedge clk); check("R3 irq after disable", {31'b0, irq_o}, 32'h0);

        // R1: reset mid-run clears configuration
        src_i = 64'h8;
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); check("R1 irq in reset", {31'b0, irq_o}, 32'h0);
        rst_n = 1'b1;
        bus_read(12'h00C, rd); check("R1 cfg3 after reset", rd, 32'h0);
        check("R1 irq stays low", {31'b0, irq_o}, 32'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule